// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. It never needs an idle cycle when the bus changes direction. Address and control are registered on every enabled rising clock edge. The data transfer for that command takes place two cycles later for both reads and writes. This fixed spacing lets a controller issue a read, a write, a read and so on, one per cycle, with every cycle carrying useful data.

The array is word-addressed. Each word is split into byte lanes, and each lane has its own active-low write strobe. A two-bit burst counter lets one loaded address drive a sequence of beats. The beats follow either a linear or an interleaved order. A clock-enable input suspends the whole pipeline. The bidirectional data bus is split into an input, a registered output and an output-drive flag. The flag is also gated without any clock by an output-enable input.

In the default configuration the array holds 256 words of 36 bits. Each word is made of four 9-bit lanes.

Top module: `zbt_pipe_sram`

## Requirements
- R1: If a read command is loaded at edge E0, the `dq_out` register takes the word at that address at edge E2. `dq_drv` is then high for the cycle between E2 and E3, as long as `oe_n` is low.
- R2: If a write command is loaded at edge E0, the word on `dq_in` during the cycle between E2 and E3 is sampled at E3 and stored at the command's address.
- R3: Reads and writes may be issued on consecutive cycles in any mix with no idle cycle. A read issued one or two cycles after a write to the same address returns the newly written bytes.
- R4: An edge at which `ce_n` is high has no effect. No command is loaded, the burst counter and all pipeline stages hold, no array write happens, and `dq_out` and `dq_drv` keep their values.
- R5: A command is loaded only when `adv_ld` is low, `sel_a_n` is low, `sel_b_n` is low and `sel_c` is high. With `adv_ld` low and any of these three false, the edge starts a deselect cycle. Commands already in the pipeline still complete.
- R6: `dq_drv` is low in the data cycle that belongs to a deselect cycle or to a write command, two cycles after that command.
- R7: `bw_n[i]` low writes lane i, which is bits [9i+8:9i]. Lanes whose strobe is high keep their old contents. Strobes are sampled with every write beat and are ignored on reads.
- R8: While `oe_n` is high, `dq_drv` is low at once, without waiting for a clock edge, whatever the pipeline holds.
- R9: With `adv_ld` high after a loaded command, `addr` and `rw` are ignored. The next beat keeps the read/write type and moves to beat n (n = 1, 2, 3, then wrapping to 0). The upper address bits stay the same. The low two bits are (start + n) mod 4 when `burst_ilv` = 0, and start XOR n when `burst_ilv` = 1.
- R10: With `adv_ld` high after a deselect cycle, no command is issued. After reset the pipeline holds only deselect cycles and `dq_drv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| ce_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| rw | input | 1 | 1 = read, 0 = write (used on load only) |
| addr | input | AW | Word address |
| bw_n | input | LANES | Per-lane write strobes, active low |
| burst_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LW | Write data from the bus |
| dq_out | output | LANES*LW | Registered read data toward the bus |
| dq_drv | output | 1 | High when the block drives the bus |

## Verification
The hardest case to reach is a read of an address whose write has not yet landed in the array. In that case the read must take the bytes straight from `dq_in`, in the same edge that commits the write, and only for the lanes that were strobed. The stimulus writes an address with a partial strobe and then reads the same address on the very next command. It also does this with one unrelated command in between, so that both spacings meet the commit. Freeze edges and deselect cycles are placed in the middle of these pairs and of bursts. This confirms that the spacing counts enabled edges only.

// File: rtl/zbt_pipe_sram.sv
`timescale 1ns/1ps
module zbt_pipe_sram #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                sel_a_n,
  input  logic                sel_b_n,
  input  logic                sel_c,
  input  logic                adv_ld,
  input  logic                rw,
  input  logic [AW-1:0]       addr,
  input  logic [LANES-1:0]    bw_n,
  input  logic                burst_ilv,
  input  logic                oe_n,
  input  logic [LANES*LW-1:0] dq_in,
  output logic [LANES*LW-1:0] dq_out,
  output logic                dq_drv
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic             s1_v, s1_wr;
  logic [AW-1:0]    s1_base;
  logic [1:0]       s1_cnt;
  logic [LANES-1:0] s1_bw;
  logic             s2_v, s2_wr;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_bw;
  logic             s3_v, s3_wr;
  logic [AW-1:0]    s3_addr;
  logic [LANES-1:0] s3_bw;

  logic          selected, hit;
  logic [1:0]    beat_lo;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] rd_word;

  assign selected = !sel_a_n && !sel_b_n && sel_c;
  assign beat_lo  = burst_ilv ? (s1_base[1:0] ^ s1_cnt) : (s1_base[1:0] + s1_cnt);
  assign s1_addr  = {s1_base[AW-1:2], beat_lo};
  assign hit      = s3_v && s3_wr && (s3_addr == s2_addr);
  assign dq_drv   = s3_v && !s3_wr && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_base <= '0; s1_cnt <= '0; s1_bw <= '1;
    end else if (!ce_n) begin
      if (!adv_ld) begin
        s1_v    <= selected;
        s1_wr   <= !rw;
        s1_base <= addr;
        s1_cnt  <= '0;
        s1_bw   <= bw_n;
      end else if (s1_v) begin
        s1_cnt <= s1_cnt + 2'd1;
        s1_bw  <= bw_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_bw <= '1;
      s3_v <= 1'b0; s3_wr <= 1'b0; s3_addr <= '0; s3_bw <= '1;
      dq_out <= '0;
    end else if (!ce_n) begin
      s2_v <= s1_v; s2_wr <= s1_wr; s2_addr <= s1_addr; s2_bw <= s1_bw;
      s3_v <= s2_v; s3_wr <= s2_wr; s3_addr <= s2_addr; s3_bw <= s2_bw;
      if (s2_v && !s2_wr) dq_out <= rd_word;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] arr [DEPTH];
    always_ff @(posedge clk)
      if (!ce_n && s3_v && s3_wr && !s3_bw[g]) arr[s3_addr] <= dq_in[g*LW +: LW];
    assign rd_word[g*LW +: LW] = (hit && !s3_bw[g]) ? dq_in[g*LW +: LW] : arr[s2_addr];
  end

  p_oe_async_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drv);
  p_write_phase_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_v && s3_wr) |-> !dq_drv);
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(dq_out) && $stable(s1_v) && $stable(s2_v) && $stable(s3_v) && $stable(s1_cnt)));
  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_ld && !selected) |=> !s1_v);
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_ld && selected && rw) |=> (s1_v && !s1_wr && s1_cnt == 2'd0));
  p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && adv_ld && s1_v) |=> (s1_v && s1_cnt == $past(s1_cnt) + 2'd1 && $stable(s1_wr)));
  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && adv_ld && !s1_v) |=> !s1_v);
endmodule

// File: tb/sim_zbt_pipe_sram.sv
`timescale 1ns/1ps
module sim_zbt_pipe_sram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, sel_a_n = 1'b1, sel_b_n = 1'b0, sel_c = 1'b1;
  logic adv_ld = 1'b0, rw = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  bw_n = '1;
  logic [35:0] dq_in = '0, dq_out, cmd_d = '0;
  logic        dq_drv;

  zbt_pipe_sram u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .adv_ld(adv_ld), .rw(rw), .addr(addr),
    .bw_n(bw_n), .burst_ilv(burst_ilv), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_drv(dq_drv));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R10";

  // reference model: op = {v, wr, addr[7:0], bw[3:0], data[35:0]}
  logic [35:0] mref [256];
  logic [49:0] q [$];
  logic [49:0] ph = '0;
  logic [35:0] exp_out = '0;
  logic        bv = 0, bwr = 0;
  logic [7:0]  bbase = '0;
  logic [1:0]  bcnt = '0;

  function automatic logic [7:0] beat_addr();
    logic [1:0] lo;
    lo = burst_ilv ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt);
    return {bbase[7:2], lo};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {50'd0, 50'd0}; ph = '0; bv = 0; bcnt = '0; exp_out = '0;
    end else if (!ce_n) begin
      if (ph[49] && ph[48])
        for (int l = 0; l < 4; l++)
          if (!ph[36+l]) mref[ph[47:40]][l*9 +: 9] = dq_in[l*9 +: 9];
      if (!adv_ld) begin
        bv = !sel_a_n && !sel_b_n && sel_c;
        bwr = !rw; bbase = addr; bcnt = 2'd0;
      end else if (bv) bcnt = bcnt + 2'd1;
      q.push_back({bv, bwr, beat_addr(), bw_n, cmd_d});
      ph = q.pop_front();
      if (ph[49] && !ph[48]) exp_out = mref[ph[47:40]];
    end
  end

  task automatic chk(input logic ok, input string what, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic cyc(input logic c_ce_n, input logic c_adv, input logic c_rw,
                     input logic [7:0] c_a, input logic [2:0] c_sel,
                     input logic [3:0] c_bw, input logic [35:0] c_d);
    logic eo;
    @(negedge clk);
    eo = ph[49] && !ph[48] && !oe_n;
    chk(dq_drv === eo, "dq_drv", {35'd0, dq_drv}, {35'd0, eo});
    if (eo) chk(dq_out === exp_out, "dq_out", dq_out, exp_out);
    dq_in = (ph[49] && ph[48]) ? ph[35:0] : {4'($urandom), 32'($urandom)};
    ce_n = c_ce_n; adv_ld = c_adv; rw = c_rw; addr = c_a;
    {sel_a_n, sel_b_n, sel_c} = c_sel; bw_n = c_bw; cmd_d = c_d;
    @(posedge clk);
  endtask

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  localparam logic [2:0] ON = 3'b001;
  task automatic rd(input logic [7:0] a);  cyc(0, 0, 1, a, ON, 4'hF, '0); endtask
  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [35:0] d);
    cyc(0, 0, 0, a, ON, b, d);
  endtask
  task automatic adv(input logic [3:0] b, input logic [35:0] d);
    cyc(0, 1, logic'($urandom), 8'($urandom), 3'($urandom), b, d);
  endtask
  task automatic desel(input logic [2:0] s); cyc(0, 0, 1, 8'($urandom), s, 4'h0, '0); endtask
  task automatic freeze(); cyc(1, logic'($urandom), logic'($urandom), 8'($urandom), 3'($urandom), 4'($urandom), rnd36()); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    req = "R10";
    chk(dq_drv === 1'b0, "reset drive", {35'd0, dq_drv}, 36'd0);
    @(negedge clk); rst_n = 1'b1;

    req = "R2";   // fill with linear write bursts (R9 linear order)
    burst_ilv = 1'b0;
    for (int b = 0; b < 256; b += 4) begin
      wr(8'(b), 4'h0, rnd36());
      for (int k = 0; k < 3; k++) adv(4'h0, rnd36());
    end
    req = "R1";
    for (int i = 0; i < 300; i++) rd(8'($urandom));

    req = "R9";   // linear read bursts from offsets; rw and addr ignored
    for (int s = 0; s < 4; s++) begin
      rd(8'(16 + s));
      for (int k = 0; k < 5; k++) adv(4'h0, '0);
    end
    req = "R10";  // advance while deselected issues nothing
    desel(3'b101); adv(4'h0, rnd36()); adv(4'h0, rnd36()); desel(3'b000);
    repeat (2) rd(8'd5);
    desel(3'b101); desel(3'b101);
    burst_ilv = 1'b1;
    req = "R9";   // interleaved write and read bursts
    for (int s = 0; s < 4; s++) begin
      wr(8'(40 + s), 4'h0, rnd36());
      for (int k = 0; k < 3; k++) adv(4'($urandom), rnd36());
      rd(8'(40 + s));
      for (int k = 0; k < 3; k++) adv(4'h0, '0);
    end
    desel(3'b101); desel(3'b101);
    burst_ilv = 1'b0;

    req = "R3";   // read right after write, same address, and one apart
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      wr(a, 4'($urandom), rnd36());
      if (i % 2) rd(8'($urandom));
      rd(a);
    end
    req = "R7";   // strobes on reads ignored; partial lanes
    for (int i = 0; i < 50; i++) begin
      cyc(0, 0, 1, 8'(i), ON, 4'h0, rnd36());
      wr(8'(i), 4'($urandom), rnd36());
      rd(8'(i));
    end

    req = "R5";   // each enable deselects; in-flight commands complete
    rd(8'd1); desel(3'b101); rd(8'd2); desel(3'b011); wr(8'd3, 4'h0, rnd36());
    desel(3'b000); rd(8'd3); desel(3'b111); rd(8'd3);
    req = "R6";
    wr(8'd9, 4'h0, rnd36()); rd(8'd9); desel(3'b101); rd(8'd9); wr(8'd9, 4'h5, rnd36());
    desel(3'b000); desel(3'b000); desel(3'b000);

    req = "R4";   // freezes between write command, data phase and read
    wr(8'd70, 4'h0, rnd36()); freeze(); rd(8'd70); freeze(); freeze();
    wr(8'd70, 4'hA, rnd36()); rd(8'd70); freeze(); rd(8'd71); freeze(); adv(4'h0, '0);
    freeze(); rd(8'd70); freeze(); freeze(); freeze();

    req = "R8";   // output enable acts without a clock
    rd(8'd12); desel(3'b101); desel(3'b101);
    #1 oe_n = 1'b1; #0.5;
    chk(dq_drv === 1'b0, "oe high", {35'd0, dq_drv}, 36'd0);
    oe_n = 1'b0; #0.5;
    chk(dq_drv === 1'b1, "oe low", {35'd0, dq_drv}, 36'd1);
    for (int i = 0; i < 40; i++) begin oe_n = logic'($urandom); rd(8'($urandom)); end
    oe_n = 1'b0;

    req = "R3";   // random mixture
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 7)
        0, 1: rd(8'($urandom));
        2, 3: wr(8'($urandom), 4'($urandom), rnd36());
        4:    adv(4'($urandom), rnd36());
        5:    freeze();
        default: desel(3'($urandom) | 3'b100);
      endcase
    end
    repeat (4) desel(3'b101);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule